// File: doc/BRIEF.md
# Programmable Interval Timer Channel

A single 16-bit down-counting timer channel advanced by a one-cycle tick enable. Software programs it through a control strobe that picks how count bytes are transferred and which operating mode runs, then loads the count one byte at a time through a byte-wide write port. The current count, or a frozen snapshot of it, comes back through a byte-wide read port, low byte first.

Three operating behaviours exist: terminal-count interrupt, where the output rises once and stays high; a rate generator, which raises an interrupt on every expiry; and a square wave, which toggles the output on every expiry. A newly written count does not start counting at once. It is copied into the counter on the following tick. In rate mode a count written while the channel runs is only picked up at the next natural reload. The interrupt request is a one-cycle pulse.

The write port applies back-pressure in a single case. `wr_ready_o` is low while `ctl_valid_i` is high, and a byte offered in that cycle is not taken. In every other cycle a byte with `wr_valid_i` high is accepted. A read request always gets its byte one cycle later, marked by `rd_valid_o`, and `rd_data_o` holds that byte until the next read.

Top module: `pit_channel`

## Requirements
- R1: After reset the channel is idle, `out_o` and `irq_o` are 0, the counter reads 0, and both the write byte pointer and the read byte pointer select the low byte.
- R2: A control strobe carries an access code in `ctl_access_i` (0 = latch count, 1 = low byte only, 2 = high byte only, 3 = low then high byte) and a mode code in `ctl_mode_i` (0 = terminal-count interrupt, 2 = rate generator, 3 = square wave; codes 1, 4 and 5 act as 0; 6 acts as 2; 7 acts as 3). A strobe with a non-zero access code stops the channel and drives `out_o` to 0.
- R3: With access 3, the first data byte fills bits 7:0 of the reload value and the second byte fills bits 15:8. Access 1 writes only bits 7:0 and access 2 writes only bits 15:8, and each byte completes a count. `wr_ready_o` is 0 exactly while `ctl_valid_i` is 1.
- R4: A completed count makes the channel pending. The reload value enters the counter on the next tick, and only then does counting begin. Ticks have no effect on an idle channel.
- R5: Each tick on a running channel decrements the counter. A tick that finds the counter at 1 is an expiry and reloads the counter. A count of 0 stands for 65536.
- R6: In terminal-count mode an expiry sets `out_o` to 1 only if it was 0, and an interrupt is raised only at that rise.
- R7: In rate mode every expiry raises an interrupt and `out_o` is left unchanged. A count completed while the channel is running does not restart it, and the new value is used at the next expiry.
- R8: In square-wave mode the loaded value and every reload have bit 0 cleared. Each expiry toggles `out_o`, and an interrupt is raised only when `out_o` goes from 0 to 1.
- R9: Reads alternate between the low byte and the high byte, starting with the low byte. Without a latch they return the live counter.
- R10: A latch command (access 0) snapshots the counter only when no snapshot is held. Reads return the snapshot, and the snapshot is released after its high byte is read.
- R11: `irq_o` is a one-cycle pulse that appears in the clock cycle after the tick that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Single-cycle count enable |
| ctl_valid_i | input | 1 | Control strobe |
| ctl_access_i | input | 2 | Access code (see R2) |
| ctl_mode_i | input | 3 | Mode code (see R2) |
| wr_valid_i | input | 1 | Count byte offered |
| wr_ready_o | output | 1 | Count byte can be taken |
| wr_data_i | input | 8 | Count byte |
| rd_req_i | input | 1 | Read request for the next byte |
| rd_valid_o | output | 1 | Read byte present (one cycle after request) |
| rd_data_o | output | 8 | Read byte |
| out_o | output | 1 | Timer output pin |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The bench targets the tick that both loads and counts. A design that decremented on the loading tick would read one less in every vector. It also probes the count of 0 and the square-wave count of 1, both of which must run as 65536; a design without that wrap would expire at once or stall. Rate-mode rewrites while running are checked, since restarting them would reset the count to the new value, and so is the second latch command, which must not overwrite the first snapshot. Interrupt counts per vector catch a terminal-count output that re-raises on later expiries and a square wave that interrupts on falling edges.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [1:0] {RUN_IDLE = 2'd0, RUN_PEND = 2'd1, RUN_ACTIVE = 2'd2} run_e;
  typedef enum logic [1:0] {MD_TERM = 2'd0, MD_RATE = 2'd1, MD_SQUARE = 2'd2} mode_e;
  typedef enum logic [1:0] {ACC_LATCH = 2'd0, ACC_LO = 2'd1, ACC_HI = 2'd2, ACC_BOTH = 2'd3} acc_e;

  function automatic mode_e decode_mode(input logic [2:0] code);
    case (code[1:0])
      2'd2: decode_mode = MD_RATE;
      2'd3: decode_mode = (code == 3'd3 || code == 3'd7) ? MD_SQUARE : MD_TERM;
      default: decode_mode = MD_TERM;
    endcase
    if (code == 3'd6) decode_mode = MD_RATE;
  endfunction
endpackage

// File: rtl/pit_ctl_regs.sv
module pit_ctl_regs
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_valid_i,
  input  logic [1:0]        ctl_access_i,
  input  logic [2:0]        ctl_mode_i,
  input  logic              wr_valid_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              running_i,
  output logic              wr_ready_o,
  output mode_e             mode_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              load_req_o,
  output logic              stop_o,
  output logic              latch_req_o
);
  acc_e  acc_q;
  mode_e mode_q;
  logic  ptr_hi_q;
  logic  wr_take;
  logic  complete;

  assign stop_o      = ctl_valid_i && (ctl_access_i != ACC_LATCH);
  assign latch_req_o = ctl_valid_i && (ctl_access_i == ACC_LATCH);
  assign wr_ready_o  = !ctl_valid_i;
  assign wr_take     = wr_valid_i && wr_ready_o;
  assign complete    = ptr_hi_q || (acc_q == ACC_LO);
  assign load_req_o  = wr_take && complete && !((mode_q == MD_RATE) && running_i);
  assign mode_o      = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= ACC_BOTH;
      mode_q   <= MD_TERM;
      ptr_hi_q <= 1'b0;
    end else if (stop_o) begin
      acc_q    <= acc_e'(ctl_access_i);
      mode_q   <= decode_mode(ctl_mode_i);
      ptr_hi_q <= (ctl_access_i == ACC_HI);
    end else if (wr_take && acc_q == ACC_BOTH) begin
      ptr_hi_q <= !ptr_hi_q;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else if (wr_take && (ptr_hi_q == (g == 1))) lane_q <= wr_data_i;
    end
    assign reload_o[g*BYTE_W +: BYTE_W] = lane_q;
  end

  AST_LO_ONLY_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q == ACC_LO) |-> !ptr_hi_q); // R3
  AST_BOTH_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_take && !stop_o && acc_q == ACC_BOTH) |=> (ptr_hi_q != $past(ptr_hi_q))); // R3
endmodule

// File: rtl/pit_count_core.sv
module pit_count_core
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  mode_e            mode_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             load_req_i,
  input  logic             stop_i,
  output logic [CNT_W-1:0] count_o,
  output logic             running_o,
  output logic             out_o,
  output logic             irq_o
);
  run_e             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;
  logic             out_q, irq_q;
  logic             expire;

  assign load_val  = (mode_i == MD_SQUARE) ? {reload_i[CNT_W-1:1], 1'b0} : reload_i;
  assign expire    = tick_i && (run_q == RUN_ACTIVE) && (cnt_q == CNT_W'(1));
  assign count_o   = cnt_q;
  assign running_o = (run_q == RUN_ACTIVE);
  assign out_o     = out_q;
  assign irq_o     = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= RUN_IDLE;
      cnt_q <= '0;
      out_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (stop_i) begin
        run_q <= RUN_IDLE;
        out_q <= 1'b0;
      end else if (load_req_i) begin
        run_q <= RUN_PEND;
      end else if (tick_i) begin
        case (run_q)
          RUN_PEND: begin
            cnt_q <= load_val;
            run_q <= RUN_ACTIVE;
          end
          RUN_ACTIVE: begin
            if (expire) begin
              cnt_q <= load_val;
              case (mode_i)
                MD_RATE: irq_q <= 1'b1;
                MD_SQUARE: begin
                  out_q <= !out_q;
                  irq_q <= !out_q;
                end
                default: begin
                  out_q <= 1'b1;
                  irq_q <= !out_q;
                end
              endcase
            end else begin
              cnt_q <= cnt_q - CNT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(tick_i)); // R11
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q == RUN_IDLE && !load_req_i) |=> $stable(cnt_q)); // R4
  AST_SQ_EVEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q == RUN_ACTIVE && $past(run_q) == RUN_PEND && mode_i == MD_SQUARE) |-> !cnt_q[0]); // R8
  AST_TERM_IRQ_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && mode_i != MD_RATE) |-> out_o); // R6
  AST_RATE_OUT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MD_RATE && !stop_i) |=> $stable(out_o)); // R7
endmodule

// File: rtl/pit_read_port.sv
module pit_read_port #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              latch_req_i,
  input  logic              rd_req_i,
  output logic              rd_valid_o,
  output logic [BYTE_W-1:0] rd_data_o
);
  logic [CNT_W-1:0]  snap_q;
  logic              held_q;
  logic              ptr_hi_q;
  logic [CNT_W-1:0]  src;
  logic              release_now;

  assign src         = held_q ? snap_q : count_i;
  assign release_now = rd_req_i && ptr_hi_q && held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q     <= '0;
      held_q     <= 1'b0;
      ptr_hi_q   <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_req_i;
      if (rd_req_i) begin
        rd_data_o <= src[ptr_hi_q*BYTE_W +: BYTE_W];
        ptr_hi_q  <= !ptr_hi_q;
      end
      if (release_now) begin
        held_q <= 1'b0;
      end else if (latch_req_i && !held_q) begin
        snap_q <= count_i;
        held_q <= 1'b1;
      end
    end
  end

  AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !release_now) |=> (held_q && $stable(snap_q))); // R10
  AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(rd_req_i)); // R9
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              ctl_valid_i,
  input  logic [1:0]        ctl_access_i,
  input  logic [2:0]        ctl_mode_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              rd_req_i,
  output logic              rd_valid_o,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              out_o,
  output logic              irq_o
);
  mode_e            mode;
  logic [CNT_W-1:0] reload, count;
  logic             load_req, stop, latch_req, running;

  pit_ctl_regs #(.BYTE_W(BYTE_W)) u_ctl (
    .clk, .rst_n, .ctl_valid_i, .ctl_access_i, .ctl_mode_i,
    .wr_valid_i, .wr_data_i, .running_i(running), .wr_ready_o,
    .mode_o(mode), .reload_o(reload), .load_req_o(load_req),
    .stop_o(stop), .latch_req_o(latch_req)
  );

  pit_count_core #(.CNT_W(CNT_W)) u_core (
    .clk, .rst_n, .tick_i, .mode_i(mode), .reload_i(reload),
    .load_req_i(load_req), .stop_i(stop), .count_o(count),
    .running_o(running), .out_o, .irq_o
  );

  pit_read_port #(.BYTE_W(BYTE_W)) u_rd (
    .clk, .rst_n, .count_i(count), .latch_req_i(latch_req),
    .rd_req_i, .rd_valid_o, .rd_data_o
  );

  AST_STOP_CLEARS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid_i && ctl_access_i != 2'd0) |=> !out_o); // R2
endmodule

// File: tb/pit_channel_tb.sv
module pit_channel_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, ctl_valid = 1'b0, wr_valid = 1'b0, rd_req = 1'b0;
  logic [1:0] ctl_access = 2'd0;
  logic [2:0] ctl_mode = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic wr_ready, rd_valid, out_pin, irq;
  logic [7:0] rd_data;

  int errors = 0, checks = 0, irq_cnt = 0;
  bit done = 1'b0;

  always #2 clk = !clk;

  pit_channel u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .ctl_valid_i(ctl_valid),
    .ctl_access_i(ctl_access), .ctl_mode_i(ctl_mode), .wr_valid_i(wr_valid),
    .wr_ready_o(wr_ready), .wr_data_i(wr_data), .rd_req_i(rd_req),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .out_o(out_pin), .irq_o(irq)
  );

  always @(negedge clk) if (irq) irq_cnt++;

  typedef struct packed {
    logic [2:0]  mode;
    logic [15:0] count;
    logic [7:0]  ticks;
    logic [15:0] exp_cnt;
    logic        exp_out;
    logic [3:0]  exp_irq;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 16'd10, 8'd1,  16'd10,     1'b0, 4'd0},
    '{3'd0, 16'd10, 8'd5,  16'd6,      1'b0, 4'd0},
    '{3'd0, 16'd5,  8'd6,  16'd5,      1'b1, 4'd1},
    '{3'd0, 16'd5,  8'd11, 16'd5,      1'b1, 4'd1},
    '{3'd2, 16'd4,  8'd9,  16'd4,      1'b0, 4'd2},
    '{3'd3, 16'd7,  8'd7,  16'd6,      1'b1, 4'd1},
    '{3'd3, 16'd7,  8'd13, 16'd6,      1'b0, 4'd1},
    '{3'd3, 16'd7,  8'd19, 16'd6,      1'b1, 4'd2},
    '{3'd0, 16'd0,  8'd3,  16'hFFFE,   1'b0, 4'd0},
    '{3'd4, 16'd3,  8'd4,  16'd3,      1'b1, 4'd1},
    '{3'd3, 16'd1,  8'd2,  16'hFFFF,   1'b0, 4'd0},
    '{3'd7, 16'd9,  8'd9,  16'd8,      1'b1, 4'd1},
    '{3'd6, 16'd2,  8'd5,  16'd2,      1'b0, 4'd2}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ctl(input logic [2:0] m, input logic [1:0] a);
    @(negedge clk); ctl_valid = 1'b1; ctl_mode = m; ctl_access = a;
    @(negedge clk); ctl_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic rd_pair(output logic [15:0] v);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0; v[7:0] = rd_data;
    rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0; v[15:8] = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 out", out_pin, 0);
    check("R1 irq", irq, 0);
    rd_pair(v);
    check("R1 count", v, 16'h0000);
    // R4 ticks ignored while idle
    ticks(3);
    rd_pair(v);
    check("R4 idle ignores ticks", v, 16'h0000);
    // R4 deferred start
    ctl(3'd0, 2'd3);
    wr(8'h34); wr(8'h12);
    rd_pair(v);
    check("R4 not loaded before tick", v, 16'h0000);
    ticks(1);
    rd_pair(v);
    check("R4 loaded on tick", v, 16'h1234);
    // R10 latch snapshot, second latch ignored
    ctl(3'd0, 2'd0);
    ticks(3);
    ctl(3'd0, 2'd0);
    rd_pair(v);
    check("R10 snapshot kept", v, 16'h1234);
    rd_pair(v);
    check("R9 live after release", v, 16'h1231);
    ctl(3'd0, 2'd0);
    ticks(1);
    rd_pair(v);
    check("R10 relatch", v, 16'h1231);
    rd_pair(v);
    check("R9 live count", v, 16'h1230);
    // R3 back-pressure
    @(negedge clk); ctl_valid = 1'b1; ctl_access = 2'd0; ctl_mode = 3'd0;
    #1 check("R3 ready low on ctl", wr_ready, 0);
    @(negedge clk); ctl_valid = 1'b0;
    #1 check("R3 ready high", wr_ready, 1);
    rd_pair(v);

    // table of vectors
    for (int k = 0; k < NV; k++) begin
      ctl(VEC[k].mode, 2'd3);
      check($sformatf("R2 stop clears out v%0d", k), out_pin, 0);
      wr(VEC[k].count[7:0]); wr(VEC[k].count[15:8]);
      irq_cnt = 0;
      ticks(int'(VEC[k].ticks));
      @(negedge clk);
      check($sformatf("R6 R8 out v%0d", k), out_pin, VEC[k].exp_out);
      check($sformatf("R11 R7 irq pulses v%0d", k), irq_cnt, VEC[k].exp_irq);
      ctl(3'd0, 2'd0);
      rd_pair(v);
      check($sformatf("R5 count v%0d", k), v, VEC[k].exp_cnt);
    end

    // R4 rewrite in terminal mode restarts
    ctl(3'd0, 2'd3);
    wr(8'd10); wr(8'd0);
    ticks(3);
    wr(8'd20); wr(8'd0);
    rd_pair(v);
    check("R4 pending keeps old count", v, 16'd8);
    ticks(1);
    rd_pair(v);
    check("R4 reload on tick", v, 16'd20);
    // R7 rate rewrite does not restart
    ctl(3'd2, 2'd3);
    wr(8'd10); wr(8'd0);
    ticks(3);
    wr(8'd3); wr(8'd0);
    ticks(1);
    rd_pair(v);
    check("R7 no restart", v, 16'd7);
    irq_cnt = 0;
    ticks(7);
    @(negedge clk);
    rd_pair(v);
    check("R7 new value at expiry", v, 16'd3);
    check("R7 irq at expiry", irq_cnt, 1);
    // R3 single-byte access modes
    ctl(3'd0, 2'd1);
    wr(8'h55);
    ticks(1);
    rd_pair(v);
    check("R3 low only", v, 16'h0055);
    wr(8'h66);
    ticks(1);
    rd_pair(v);
    check("R3 low only repeat", v, 16'h0066);
    ctl(3'd0, 2'd2);
    wr(8'h02);
    ticks(1);
    rd_pair(v);
    check("R3 high only", v, 16'h0266);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule